// File: doc/BRIEF.md
# Bidirectional Processor Mailbox with Arrival Interrupt

Two processors, called side A and side B, pass 32-bit words to each other through two separate queues, one for each direction. A side pushes words into its send queue and pops words from its receive queue. Both ends of each queue can see its empty and full state and how many words it holds. A sender that sees its queue full is expected to wait. A read by the far side frees a slot for the next word.

Each side has a sticky arrival flag. The flag is raised only when that side's receive queue changes from holding nothing to holding data. Words that remain after a partial read never raise it again. A new arrival event needs a full drain followed by a fresh write. A small occupancy state machine per side, with states `ST_DRAINED` and `ST_LOADED`, makes this decision. Its "fill" transition (drained to loaded) produces the event, and its "drain" transition returns it to `ST_DRAINED`. A second state machine, with states `FL_IDLE` and `FL_PENDING`, holds the flag. Its "raise" transition is taken on an event. Its "ack" transition is taken on a write-one-to-clear strobe. When both happen in the same cycle, "raise" wins.

The interrupt line is the flag gated by a per-side enable register. Each side also keeps a sticky error bit, which records a push into a full queue or a pop from an empty one.

Top module: `ipc_mailbox`

## Requirements
- R1: The A-to-B and B-to-A queues are independent 16-word by 32-bit first-in first-out stores. Words come out in the order they went in, and filling one queue leaves the other unchanged.
- R2: Each queue reports `empty` (count 0), `full` (count 16) and its current count. These values update in the cycle after the edge that accepts a push or a pop.
- R3: A push into a full queue is dropped and the count stays the same. The sending side's error bit is set from the next cycle.
- R4: Each pop updates the registered receive data one cycle later. A pop from an empty queue keeps the last word delivered and sets the receiving side's error bit.
- R5: The arrival flag becomes 1 in the second cycle after the edge that writes into an empty receive queue. It is 0 in the first cycle after that edge.
- R6: No arrival event occurs while the receive queue still holds words. After the queue drains to empty and is written again, the flag rises again.
- R7: The arrival flag holds its value until a clear strobe writes 1 in bit 0 of the clear data. It reads 0 from the next cycle.
- R8: If a clear of the flag and a new arrival event fall in the same cycle, the flag stays 1.
- R9: The interrupt output is the flag AND the enable register. Writing enable = 1 while the flag is set asserts the interrupt from the next cycle.
- R10: The error bit stays set until a clear strobe writes 1 in bit 1 of the clear data.
- R11: Reset empties both queues and clears all flags, enables, error bits and interrupts.
- R12: After a pop from a full queue, a push that refills the freed slot raises no arrival event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_send_we | input | 1 | Side A push strobe |
| a_send_data | input | 32 | Side A push word |
| a_tx_full | output | 1 | A-to-B queue full |
| a_tx_empty | output | 1 | A-to-B queue empty |
| a_tx_count | output | 5 | A-to-B occupancy |
| a_recv_re | input | 1 | Side A pop strobe |
| a_recv_data | output | 32 | Last word popped by side A |
| a_rx_empty | output | 1 | B-to-A queue empty |
| a_rx_full | output | 1 | B-to-A queue full |
| a_rx_count | output | 5 | B-to-A occupancy |
| a_ien_we | input | 1 | Side A enable write strobe |
| a_ien_wdata | input | 1 | Side A enable value |
| a_clr_we | input | 1 | Side A clear strobe |
| a_clr_wdata | input | 2 | Bit 0 clears the flag, bit 1 clears the error |
| a_irq_flag | output | 1 | Side A arrival flag |
| a_irq_en | output | 1 | Side A enable |
| a_err | output | 1 | Side A error bit |
| a_irq | output | 1 | Interrupt to side A |
| b_send_we | input | 1 | Side B push strobe |
| b_send_data | input | 32 | Side B push word |
| b_tx_full | output | 1 | B-to-A queue full |
| b_tx_empty | output | 1 | B-to-A queue empty |
| b_tx_count | output | 5 | B-to-A occupancy |
| b_recv_re | input | 1 | Side B pop strobe |
| b_recv_data | output | 32 | Last word popped by side B |
| b_rx_empty | output | 1 | A-to-B queue empty |
| b_rx_full | output | 1 | A-to-B queue full |
| b_rx_count | output | 5 | A-to-B occupancy |
| b_ien_we | input | 1 | Side B enable write strobe |
| b_ien_wdata | input | 1 | Side B enable value |
| b_clr_we | input | 1 | Side B clear strobe |
| b_clr_wdata | input | 2 | Bit 0 clears the flag, bit 1 clears the error |
| b_irq_flag | output | 1 | Side B arrival flag |
| b_irq_en | output | 1 | Side B enable |
| b_err | output | 1 | Side B error bit |
| b_irq | output | 1 | Interrupt to side B |

## Verification
The hardest case to reach is the race between a handler's clear and a new arrival. It happens when the queue drains, gets written again, and the clear strobe lands in exactly the cycle the "fill" transition fires. The stimulus first empties the queue and lets the occupancy machine settle in `ST_DRAINED`. It then pushes one word and drives the clear in the very next cycle. Another case that is hard to reach is a refill of a slot freed in a full queue. To reach it, the queue is filled to 16 and the flag cleared, then a pop is followed by a push, and the bench confirms that the flag stays at 0.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    typedef enum logic {
        ST_DRAINED = 1'b0,
        ST_LOADED  = 1'b1
    } occ_state_t;

    typedef enum logic {
        FL_IDLE    = 1'b0,
        FL_PENDING = 1'b1
    } flag_state_t;

    localparam int CLR_FLAG_BIT = 0;
    localparam int CLR_ERR_BIT  = 1;
endpackage

// File: rtl/ipc_fifo.sv
module ipc_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count,
    output logic          ovf,
    output logic          udf
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    always_comb begin
        empty   = (count == '0);
        full    = (count == FULL_CNT);
        push_ok = push & ~full;
        pop_ok  = pop & ~empty;
        ovf     = push & full;
        udf     = pop & empty;
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rdata  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
                rdata  <= mem[rd_ptr];
            end
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == FULL_CNT)); // R3
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(rdata)); // R4
endmodule

// File: rtl/ipc_side_ctl.sv
module ipc_side_ctl
    import ipc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_empty,
    input  logic clr_flag,
    input  logic clr_err,
    input  logic err_evt,
    input  logic en_we,
    input  logic en_wdata,
    output logic flag,
    output logic en,
    output logic err,
    output logic irq
);
    occ_state_t  occ_q, occ_d;
    flag_state_t fl_q, fl_d;
    logic        rise_evt;

    // occupancy tracker: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= ST_DRAINED;
            fl_q  <= FL_IDLE;
        end else begin
            occ_q <= occ_d;
            fl_q  <= fl_d;
        end
    end

    // next-state logic for both machines
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            ST_DRAINED: if (!rx_empty) occ_d = ST_LOADED;   // fill
            ST_LOADED:  if (rx_empty)  occ_d = ST_DRAINED;  // drain
            default:    occ_d = ST_DRAINED;
        endcase
        fl_d = fl_q;
        unique case (fl_q)
            FL_IDLE:    if (rise_evt) fl_d = FL_PENDING;                // raise
            FL_PENDING: if (clr_flag && !rise_evt) fl_d = FL_IDLE;     // ack
            default:    fl_d = FL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rise_evt = (occ_q == ST_DRAINED) && !rx_empty;
        flag     = (fl_q == FL_PENDING);
        irq      = flag & en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en  <= 1'b0;
            err <= 1'b0;
        end else begin
            if (en_we) begin
                en <= en_wdata;
            end
            if (err_evt) begin
                err <= 1'b1;
            end else if (clr_err) begin
                err <= 1'b0;
            end
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_flag) |=> flag); // R7
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !rise_evt) |=> !flag); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_evt && clr_flag) |=> flag); // R8
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && occ_q == ST_LOADED && !rx_empty) |=> !flag); // R6
    AST_IRQ_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && en_wdata && flag && !clr_flag) |=> irq); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_err) |=> err); // R10
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_send_we,
    input  logic [DW-1:0] a_send_data,
    output logic          a_tx_full,
    output logic          a_tx_empty,
    output logic [CW-1:0] a_tx_count,
    input  logic          a_recv_re,
    output logic [DW-1:0] a_recv_data,
    output logic          a_rx_empty,
    output logic          a_rx_full,
    output logic [CW-1:0] a_rx_count,
    input  logic          a_ien_we,
    input  logic          a_ien_wdata,
    input  logic          a_clr_we,
    input  logic [1:0]    a_clr_wdata,
    output logic          a_irq_flag,
    output logic          a_irq_en,
    output logic          a_err,
    output logic          a_irq,
    input  logic          b_send_we,
    input  logic [DW-1:0] b_send_data,
    output logic          b_tx_full,
    output logic          b_tx_empty,
    output logic [CW-1:0] b_tx_count,
    input  logic          b_recv_re,
    output logic [DW-1:0] b_recv_data,
    output logic          b_rx_empty,
    output logic          b_rx_full,
    output logic [CW-1:0] b_rx_count,
    input  logic          b_ien_we,
    input  logic          b_ien_wdata,
    input  logic          b_clr_we,
    input  logic [1:0]    b_clr_wdata,
    output logic          b_irq_flag,
    output logic          b_irq_en,
    output logic          b_err,
    output logic          b_irq
);
    localparam int NSIDE = 2;

    // index 0: queue sent by A / control of side A; index 1: B
    logic [NSIDE-1:0] push_v, pop_v, empty_v, full_v, ovf_v, udf_v;
    logic [DW-1:0]    wdata_v [NSIDE];
    logic [DW-1:0]    rdata_v [NSIDE];
    logic [CW-1:0]    cnt_v   [NSIDE];
    logic [NSIDE-1:0] clr_flag_v, clr_err_v, ien_we_v, ien_wd_v;
    logic [NSIDE-1:0] flag_v, en_v, err_v, irq_v;

    always_comb begin
        push_v     = {b_send_we, a_send_we};
        wdata_v[0] = a_send_data;
        wdata_v[1] = b_send_data;
        pop_v      = {a_recv_re, b_recv_re};   // queue 0 read by B
        clr_flag_v = {b_clr_we & b_clr_wdata[CLR_FLAG_BIT],
                      a_clr_we & a_clr_wdata[CLR_FLAG_BIT]};
        clr_err_v  = {b_clr_we & b_clr_wdata[CLR_ERR_BIT],
                      a_clr_we & a_clr_wdata[CLR_ERR_BIT]};
        ien_we_v   = {b_ien_we, a_ien_we};
        ien_wd_v   = {b_ien_wdata, a_ien_wdata};
    end

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        localparam int RX = NSIDE - 1 - g;

        ipc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[g]),
            .wdata (wdata_v[g]),
            .pop   (pop_v[g]),
            .rdata (rdata_v[g]),
            .empty (empty_v[g]),
            .full  (full_v[g]),
            .count (cnt_v[g]),
            .ovf   (ovf_v[g]),
            .udf   (udf_v[g])
        );

        ipc_side_ctl u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .rx_empty (empty_v[RX]),
            .clr_flag (clr_flag_v[g]),
            .clr_err  (clr_err_v[g]),
            .err_evt  (ovf_v[g] | udf_v[RX]),
            .en_we    (ien_we_v[g]),
            .en_wdata (ien_wd_v[g]),
            .flag     (flag_v[g]),
            .en       (en_v[g]),
            .err      (err_v[g]),
            .irq      (irq_v[g])
        );
    end

    always_comb begin
        a_tx_full   = full_v[0];
        a_tx_empty  = empty_v[0];
        a_tx_count  = cnt_v[0];
        a_recv_data = rdata_v[1];
        a_rx_empty  = empty_v[1];
        a_rx_full   = full_v[1];
        a_rx_count  = cnt_v[1];
        a_irq_flag  = flag_v[0];
        a_irq_en    = en_v[0];
        a_err       = err_v[0];
        a_irq       = irq_v[0];
        b_tx_full   = full_v[1];
        b_tx_empty  = empty_v[1];
        b_tx_count  = cnt_v[1];
        b_recv_data = rdata_v[0];
        b_rx_empty  = empty_v[0];
        b_rx_full   = full_v[0];
        b_rx_count  = cnt_v[0];
        b_irq_flag  = flag_v[1];
        b_irq_en    = en_v[1];
        b_err       = err_v[1];
        b_irq       = irq_v[1];
    end

    AST_QUEUES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (a_send_we && !b_send_we && !a_recv_re) |=> $stable(a_rx_count)); // R1
endmodule

// File: tb/sim_ipc_mailbox.sv
`timescale 1ns/1ps
module sim_ipc_mailbox;
    logic clk = 1'b0;
    logic rst_n;
    always #2 clk = ~clk;

    logic        a_send_we, a_recv_re, a_ien_we, a_ien_wdata, a_clr_we;
    logic [31:0] a_send_data;
    logic [1:0]  a_clr_wdata;
    logic        b_send_we, b_recv_re, b_ien_we, b_ien_wdata, b_clr_we;
    logic [31:0] b_send_data;
    logic [1:0]  b_clr_wdata;
    logic        a_tx_full, a_tx_empty, a_rx_empty, a_rx_full, a_irq_flag, a_irq_en, a_err, a_irq;
    logic        b_tx_full, b_tx_empty, b_rx_empty, b_rx_full, b_irq_flag, b_irq_en, b_err, b_irq;
    logic [4:0]  a_tx_count, a_rx_count, b_tx_count, b_rx_count;
    logic [31:0] a_recv_data, b_recv_data;

    ipc_mailbox u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic        side;   // 0: A sends, 1: B sends
        logic [31:0] data;
        logic [4:0]  cnt;    // expected sender count after push
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 32'h1111_0001, 5'd1},
        '{1'b1, 32'h2222_0001, 5'd1},
        '{1'b0, 32'h1111_0002, 5'd2},
        '{1'b0, 32'h1111_0003, 5'd3},
        '{1'b1, 32'h2222_0002, 5'd2},
        '{1'b0, 32'h1111_0004, 5'd4},
        '{1'b1, 32'h2222_0003, 5'd3},
        '{1'b1, 32'h2222_0004, 5'd4}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic side, input logic [31:0] d);
        if (side) begin b_send_we = 1'b1; b_send_data = d; end
        else      begin a_send_we = 1'b1; a_send_data = d; end
        tick();
        a_send_we = 1'b0;
        b_send_we = 1'b0;
    endtask

    task automatic pop(input logic side);
        if (side) b_recv_re = 1'b1; else a_recv_re = 1'b1;
        tick();
        a_recv_re = 1'b0;
        b_recv_re = 1'b0;
    endtask

    task automatic clr(input logic side, input logic [1:0] bits);
        if (side) begin b_clr_we = 1'b1; b_clr_wdata = bits; end
        else      begin a_clr_we = 1'b1; a_clr_wdata = bits; end
        tick();
        a_clr_we = 1'b0;
        b_clr_we = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R11 actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        rst_n = 1'b0;
        {a_send_we, a_recv_re, a_ien_we, a_ien_wdata, a_clr_we} = '0;
        {b_send_we, b_recv_re, b_ien_we, b_ien_wdata, b_clr_we} = '0;
        a_send_data = '0; b_send_data = '0; a_clr_wdata = '0; b_clr_wdata = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R11 reset state
        chk("R11 a_tx_empty", 32'(a_tx_empty), 1);
        chk("R11 b_tx_count", 32'(b_tx_count), 0);
        chk("R11 flags/irq", 32'({a_irq_flag, b_irq_flag, a_irq, b_irq, a_err, b_err}), 0);

        // R1 R2 vector table
        for (int i = 0; i < 8; i++) begin
            push(VEC[i].side, VEC[i].data);
            if (VEC[i].side) chk("R2 b_tx_count", 32'(b_tx_count), 32'(VEC[i].cnt));
            else             chk("R2 a_tx_count", 32'(a_tx_count), 32'(VEC[i].cnt));
        end
        chk("R2 b_rx_empty", 32'(b_rx_empty), 0);
        for (int i = 0; i < 8; i++) begin
            pop(!VEC[i].side);
            if (VEC[i].side) chk("R1 order to A", a_recv_data, VEC[i].data);
            else             chk("R1 order to B", b_recv_data, VEC[i].data);
        end
        chk("R2 both empty", 32'({a_rx_empty, b_rx_empty}), 32'b11);
        clr(1'b0, 2'b01);
        clr(1'b1, 2'b01);
        chk("R7 flags cleared", 32'({a_irq_flag, b_irq_flag}), 0);

        // R5 arrival timing
        push(1'b0, 32'hC0DE_0001);
        chk("R5 flag not yet", 32'(b_irq_flag), 0);
        tick();
        chk("R5 flag set", 32'(b_irq_flag), 1);
        chk("R9 irq masked", 32'(b_irq), 0);

        // R9 enable with flag set
        b_ien_we = 1'b1; b_ien_wdata = 1'b1;
        tick();
        b_ien_we = 1'b0;
        chk("R9 irq on enable", 32'(b_irq), 1);

        // R7 sticky and clear
        tick(); tick(); tick();
        chk("R7 sticky", 32'(b_irq_flag), 1);
        clr(1'b1, 2'b01);
        chk("R7 cleared", 32'({b_irq_flag, b_irq}), 0);

        // R6 no event while data remains, re-arm after drain
        push(1'b0, 32'hC0DE_0002);
        tick();
        chk("R6 no event with data", 32'(b_irq_flag), 0);
        pop(1'b1);
        chk("R1 data 1", b_recv_data, 32'hC0DE_0001);
        tick();
        chk("R6 no event after partial read", 32'(b_irq_flag), 0);
        pop(1'b1);
        chk("R1 data 2", b_recv_data, 32'hC0DE_0002);
        tick();
        push(1'b0, 32'hC0DE_0003);
        tick();
        chk("R6 re-armed", 32'(b_irq_flag), 1);

        // R8 set beats clear
        pop(1'b1);
        clr(1'b1, 2'b01);
        chk("R8 pre clear", 32'(b_irq_flag), 0);
        push(1'b0, 32'hC0DE_0004);
        clr(1'b1, 2'b01);
        chk("R8 set wins", 32'(b_irq_flag), 1);
        pop(1'b1);
        clr(1'b1, 2'b01);
        chk("R8 later clear", 32'(b_irq_flag), 0);

        // R3 overflow
        for (int i = 0; i < 16; i++) push(1'b0, 32'hA500_0000 + 32'(i));
        chk("R2 full", 32'({a_tx_full, b_rx_full}), 32'b11);
        chk("R2 count 16", 32'(a_tx_count), 16);
        clr(1'b1, 2'b01);
        push(1'b0, 32'hDEAD_BEEF);
        chk("R3 count held", 32'(a_tx_count), 16);
        chk("R3 a_err", 32'(a_err), 1);
        chk("R3 b_err clean", 32'(b_err), 0);
        chk("R1 other queue", 32'({a_rx_empty, b_tx_full, b_tx_count}), 32'({1'b1, 1'b0, 5'd0}));

        // R12 refill after read
        pop(1'b1);
        chk("R1 head", b_recv_data, 32'hA500_0000);
        push(1'b0, 32'hA500_0010);
        tick();
        chk("R12 no event", 32'(b_irq_flag), 0);
        chk("R12 count", 32'(b_rx_count), 16);

        // R10 clear error
        clr(1'b0, 2'b10);
        chk("R10 a_err cleared", 32'(a_err), 0);

        // R4 drain and underflow
        for (int i = 1; i <= 16; i++) begin
            pop(1'b1);
            chk("R1 drain order", b_recv_data, 32'hA500_0000 + 32'(i));
        end
        chk("R4 empty", 32'(b_rx_empty), 1);
        pop(1'b1);
        chk("R4 last word held", b_recv_data, 32'hA500_0010);
        chk("R4 b_err", 32'(b_err), 1);
        tick();
        chk("R10 err sticky", 32'(b_err), 1);
        clr(1'b1, 2'b10);
        chk("R10 b_err cleared", 32'(b_err), 0);

        // R11 reset mid-run
        push(1'b0, 32'h5555_0001);
        push(1'b1, 32'h6666_0001);
        tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk("R11 queues empty", 32'({a_tx_empty, b_tx_empty}), 32'b11);
        chk("R11 all cleared", 32'({a_irq_flag, b_irq_flag, a_irq_en, b_irq_en, a_irq, b_irq}), 0);

        finish_up();
    end
endmodule